// File: doc/BRIEF.md
# Phase-Delayed Skewed PWM Event Counter

This block produces one output pulse per reference event, positioned a programmable number of counting ticks after that event. Two 8-bit counters share one tick source, chosen by software. The tick can be every system clock cycle, a divided system clock, or the rising edges of an external clock pin. When an internal source is in use, a gate pin can hold counting off. A rising edge on the reference pin clears the phase counter and arms it. When the phase counter reaches the programmed delay, it clears and starts the pulse counter, and the phase counter then holds until the next reference edge.

The pulse counter places the two edges of the output pulse. The leading edge falls at the skew value and the trailing edge at the width value, so the pulse lasts width minus skew ticks. The trailing edge does not depend on the skew. Two sticky flags record the trailing-edge match and a second match on the phase counter. Each flag drives an interrupt line through its own enable bit. All settings pass through a small register write and read port.

Top module: `evc_phase_pwm`

## Requirements
- R1: After reset, `pwm_out`, `irq_evt1` and `irq_evt2` are 0, and every register reads 0.
- R2: The tick source is set by control bits [1:0]. Value 0 ticks every clock cycle. Value 1 ticks once every DIV cycles. Value 2 ticks once per rising edge of `ext_clk_pin`. Value 3 never ticks.
- R3: When control bit 2 is set and the source is 0 or 1, ticks occur only while the synchronized `gate_pin` is high. With source 2, `gate_pin` has no effect.
- R4: A rising edge on `ref_pin` clears the phase counter and arms it, and also cancels any sequence in progress. Each tick then advances the armed phase counter. On the tick where it equals the phase register (address 0), the pulse counter is cleared and started, and the phase counter holds at that value until the next reference edge. The phase counter reads at address 6.
- R5: The output rises when the pulse counter reaches the skew register (address 2). With skew 0 it rises in the same cycle the pulse counter is started. With source 0 and the reference edge first sampled at clock edge 1, the output rises at edge X+skew+4.
- R6: The output falls, and the pulse counter stops, when the pulse counter reaches the width register (address 1). With source 0 this is at edge X+Y+4, whatever the skew. The pulse lasts Y-skew ticks. The pulse counter reads at address 7.
- R7: If skew is greater than or equal to width, the output stays low for the whole sequence.
- R8: The width match sets flag 1 (status address 5, bit 0). The flag stays set until 1 is written to that bit. `irq_evt1` is flag 1 AND control bit 3.
- R9: On a tick where the armed phase counter equals the event register (address 3), flag 2 (status bit 1) is set. Values above the phase register are never reached. Flag 2 is cleared by writing 1 to that bit. `irq_evt2` is flag 2 AND control bit 4.
- R10: The control register is at address 4, and bits [4:0] read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` |
| ext_clk_pin | input | 1 | External count clock (asynchronous) |
| gate_pin | input | 1 | Count gate for internal sources (asynchronous) |
| ref_pin | input | 1 | Reference event, rising edge restarts (asynchronous) |
| pwm_out | output | 1 | Delayed, skewed pulse output |
| irq_evt1 | output | 1 | Width-match interrupt |
| irq_evt2 | output | 1 | Phase event-match interrupt |

## Verification
The bench builds the block with CW=8, SYNC_STAGES=2 and DIV=4. The short divider brings the prescaled source within a few dozen cycles, and the bench checks that it stretches each pulse tick to four clock cycles. With two synchronizer stages, the reference-to-edge latency is a fixed four cycles plus the programmed counts, so edges are checked against exact clock indices. Eight-bit registers keep zero-skew, skew-above-width and restart-mid-sequence cases short enough for directed runs.

// File: rtl/evc_pkg.sv
package evc_pkg;
   localparam int ADR_W = 3;

   localparam logic [ADR_W-1:0] ADR_PHASE = 3'd0;
   localparam logic [ADR_W-1:0] ADR_WIDTH = 3'd1;
   localparam logic [ADR_W-1:0] ADR_SKEW  = 3'd2;
   localparam logic [ADR_W-1:0] ADR_EVENT = 3'd3;
   localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd4;
   localparam logic [ADR_W-1:0] ADR_STAT  = 3'd5;
   localparam logic [ADR_W-1:0] ADR_PCNT  = 3'd6;
   localparam logic [ADR_W-1:0] ADR_WCNT  = 3'd7;

   localparam int CTRL_W = 5;

   typedef enum logic [1:0] {
      SRC_SYS = 2'd0,
      SRC_DIV = 2'd1,
      SRC_EXT = 2'd2,
      SRC_OFF = 2'd3
   } clk_src_e;

   typedef struct packed {
      logic     irq2_en;
      logic     irq1_en;
      logic     gate_en;
      clk_src_e src;
   } ctrl_t;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level
);
   logic [STAGES-1:0] chain_q;

   initial begin
      assert (STAGES >= 2) else $error("evc_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin};
   end

   assign level = chain_q[STAGES-1];
endmodule

// File: rtl/evc_tick_gen.sv
module evc_tick_gen
   import evc_pkg::*;
#(
   parameter int DIV = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  clk_src_e src,
   input  logic     gate_en,
   input  logic     gate_lvl,
   input  logic     ext_rise,
   output logic     tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit POW2 = ((1 << PW) == DIV);

   logic [PW-1:0] pre_q;
   logic          div_pulse;
   logic          base;

   initial begin
      assert (DIV >= 2) else $error("evc_tick_gen: DIV must be at least 2");
   end

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
         end
         assign div_pulse = &pre_q;
      end else begin : g_mod
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end
         assign div_pulse = (pre_q == LAST);
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_SYS: base = 1'b1;
         SRC_DIV: base = div_pulse;
         SRC_EXT: base = ext_rise;
         default: base = 1'b0;
      endcase
   end

   assign tick = base & ((src == SRC_EXT) | ~gate_en | gate_lvl);

   AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R2
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_OFF) |-> !tick); // R2
endmodule

// File: rtl/evc_phase_ctr.sv
module evc_phase_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ref_clr,
   input  logic [CW-1:0] phase_val,
   input  logic [CW-1:0] event_val,
   output logic [CW-1:0] cnt,
   output logic          start,
   output logic          event_hit
);
   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic          step;

   assign step      = armed_q & tick & ~ref_clr;
   assign start     = step & (cnt_q == phase_val);
   assign event_hit = step & (cnt_q == event_val);
   assign cnt       = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (ref_clr) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (step) begin
         if (cnt_q == phase_val) armed_q <= 1'b0;
         else                    cnt_q   <= cnt_q + 1'b1;
      end
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !ref_clr) |=> $stable(cnt_q)); // R4
   AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start); // R4
   AST_REF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_clr |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/evc_pwm_ctr.sv
module evc_pwm_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic [CW-1:0] width,
   input  logic [CW-1:0] skew,
   output logic [CW-1:0] cnt,
   output logic          pulse,
   output logic          trail_hit
);
   logic          run_q;
   logic          out_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic          adv;

   assign cnt_nx    = cnt_q + 1'b1;
   assign adv       = run_q & tick & ~start;
   assign trail_hit = (start & (width == '0)) | (adv & (cnt_nx == width));
   assign cnt       = cnt_q;
   assign pulse     = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         out_q <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         run_q <= (width != '0);
         out_q <= (skew == '0) && (width != '0);
      end else if (adv) begin
         cnt_q <= cnt_nx;
         if (cnt_nx == width) begin
            run_q <= 1'b0;
            out_q <= 1'b0;
         end else if (cnt_nx == skew) begin
            out_q <= 1'b1;
         end
      end
   end

   AST_RISE_AT_SKEW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> (cnt_q == $past(skew))); // R5
   AST_FALL_AT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(out_q) && !$past(start)) |-> (cnt_q == $past(width))); // R6
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !out_q); // R7
endmodule

// File: rtl/evc_phase_pwm.sv
module evc_phase_pwm
   import evc_pkg::*;
#(
   parameter int CW          = 8,
   parameter int DIV         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [ADR_W-1:0] reg_addr,
   input  logic [CW-1:0]    reg_wdata,
   output logic [CW-1:0]    reg_rdata,
   input  logic             ext_clk_pin,
   input  logic             gate_pin,
   input  logic             ref_pin,
   output logic             pwm_out,
   output logic             irq_evt1,
   output logic             irq_evt2
);
   localparam int PAD_W = CW - CTRL_W;

   initial begin
      assert (CW >= CTRL_W && CW <= 16) else $error("evc_phase_pwm: CW out of range");
   end

   logic [CW-1:0] phase_q, width_q, skew_q, event_q;
   ctrl_t         ctrl_q;
   logic          flag1_q, flag2_q;
   logic          ref_lvl, gate_lvl, ext_lvl;
   logic          ref_prev_q, ext_prev_q;
   logic          ref_rise, ext_rise;
   logic          tick, start, event_hit, trail_hit;
   logic [CW-1:0] pcnt, wcnt;
   logic          wr_stat;

   evc_sync #(.STAGES(SYNC_STAGES)) u_sync_ref  (.clk(clk), .rst_n(rst_n), .pin(ref_pin),     .level(ref_lvl));
   evc_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (.clk(clk), .rst_n(rst_n), .pin(gate_pin),    .level(gate_lvl));
   evc_sync #(.STAGES(SYNC_STAGES)) u_sync_ext  (.clk(clk), .rst_n(rst_n), .pin(ext_clk_pin), .level(ext_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_prev_q <= 1'b0;
         ext_prev_q <= 1'b0;
      end else begin
         ref_prev_q <= ref_lvl;
         ext_prev_q <= ext_lvl;
      end
   end

   assign ref_rise = ref_lvl & ~ref_prev_q;
   assign ext_rise = ext_lvl & ~ext_prev_q;

   evc_tick_gen #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .src(ctrl_q.src), .gate_en(ctrl_q.gate_en),
      .gate_lvl(gate_lvl), .ext_rise(ext_rise), .tick(tick));

   evc_phase_ctr #(.CW(CW)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ref_clr(ref_rise),
      .phase_val(phase_q), .event_val(event_q), .cnt(pcnt),
      .start(start), .event_hit(event_hit));

   evc_pwm_ctr #(.CW(CW)) u_pwm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .width(width_q), .skew(skew_q), .cnt(wcnt),
      .pulse(pwm_out), .trail_hit(trail_hit));

   assign wr_stat = reg_we && (reg_addr == ADR_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         width_q <= '0;
         skew_q  <= '0;
         event_q <= '0;
         ctrl_q  <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            ADR_PHASE: phase_q <= reg_wdata;
            ADR_WIDTH: width_q <= reg_wdata;
            ADR_SKEW:  skew_q  <= reg_wdata;
            ADR_EVENT: event_q <= reg_wdata;
            ADR_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag1_q <= 1'b0;
         flag2_q <= 1'b0;
      end else begin
         flag1_q <= trail_hit | (flag1_q & ~(wr_stat & reg_wdata[0]));
         flag2_q <= event_hit | (flag2_q & ~(wr_stat & reg_wdata[1]));
      end
   end

   assign irq_evt1 = flag1_q & ctrl_q.irq1_en;
   assign irq_evt2 = flag2_q & ctrl_q.irq2_en;

   always_comb begin
      case (reg_addr)
         ADR_PHASE: reg_rdata = phase_q;
         ADR_WIDTH: reg_rdata = width_q;
         ADR_SKEW:  reg_rdata = skew_q;
         ADR_EVENT: reg_rdata = event_q;
         ADR_CTRL:  reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
         ADR_STAT:  reg_rdata = {{(CW-2){1'b0}}, flag2_q, flag1_q};
         ADR_PCNT:  reg_rdata = pcnt;
         default:   reg_rdata = wcnt;
      endcase
   end

   AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag1_q && !(wr_stat && reg_wdata[0])) |=> flag1_q); // R8
   AST_FLAG1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag1_q) |-> $past(trail_hit)); // R8
   AST_FLAG2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag2_q) |-> $past(event_hit)); // R9
   AST_OUT_FALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwm_out) && !$past(start)) |-> flag1_q); // R6
endmodule

// File: tb/evc_phase_pwm_bench.sv
module evc_phase_pwm_bench;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [CW-1:0] reg_wdata = '0;
   logic [CW-1:0] reg_rdata;
   logic          ext_clk_pin = 1'b0;
   logic          gate_pin = 1'b0;
   logic          ref_pin = 1'b0;
   logic          pwm_out, irq_evt1, irq_evt2;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   evc_phase_pwm #(.CW(CW), .DIV(4), .SYNC_STAGES(2)) u_evc_phase_pwm (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk_pin(ext_clk_pin),
      .gate_pin(gate_pin), .ref_pin(ref_pin), .pwm_out(pwm_out),
      .irq_evt1(irq_evt1), .irq_evt2(irq_evt2));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   task automatic setup(input int x, input int sk, input int y, input int ev, input int ctl);
      wr(3'd0, CW'(x)); wr(3'd2, CW'(sk)); wr(3'd1, CW'(y));
      wr(3'd3, CW'(ev)); wr(3'd4, CW'(ctl)); wr(3'd5, 8'h03);
   endtask

   // Drive ref rising edge, count clock edges from the first sampling edge.
   task automatic measure(input int lim, output int rise, output int fall);
      int n;
      @(negedge clk);
      ref_pin = 1'b1;
      rise = -1; fall = -1; n = 0;
      for (int i = 0; i < lim; i++) begin
         @(posedge clk);
         n++;
         #1;
         if (pwm_out && rise < 0) rise = n;
         if (!pwm_out && rise >= 0 && fall < 0) fall = n;
         if (n == 2) ref_pin = 1'b0;
      end
   endtask

   task automatic t_reset();
      int v;
      check(pwm_out == 1'b0, "R1 out", int'(pwm_out), 0);
      check(irq_evt1 == 1'b0 && irq_evt2 == 1'b0, "R1 irq", int'({irq_evt2, irq_evt1}), 0);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check(v == 0, "R1 reg", v, 0);
      end
   endtask

   task automatic t_ctrl_readback();
      int v;
      wr(3'd4, 8'hFF);
      rd(3'd4, v);
      check(v == 8'h1F, "R10 ctrl", v, 8'h1F);
   endtask

   task automatic t_basic();
      int r, f, v;
      setup(3, 2, 7, 1, 8'h18);
      measure(30, r, f);
      check(r == 9, "R5 rise", r, 9);
      check(f == 14, "R6 fall", f, 14);
      rd(3'd5, v);
      check(v == 3, "R8 R9 flags", v, 3);
      check(irq_evt1 && irq_evt2, "R8 R9 irq", int'({irq_evt2, irq_evt1}), 3);
      rd(3'd6, v);
      check(v == 3, "R4 phase hold", v, 3);
      rd(3'd7, v);
      check(v == 7, "R6 pwm stop", v, 7);
      wr(3'd5, 8'h01);
      #1 check(!irq_evt1 && irq_evt2, "R8 clear", int'({irq_evt2, irq_evt1}), 2);
      wr(3'd5, 8'h02);
      #1 check(!irq_evt2, "R9 clear", int'(irq_evt2), 0);
   endtask

   task automatic t_skew_zero();
      int r, f;
      setup(0, 0, 3, 9, 8'h00);
      measure(20, r, f);
      check(r == 4, "R5 zero skew rise", r, 4);
      check(f == 7, "R6 zero skew fall", f, 7);
   endtask

   task automatic t_trail_indep();
      int r, f;
      setup(3, 0, 7, 9, 8'h00);
      measure(30, r, f);
      check(r == 7, "R5 rise", r, 7);
      check(f == 14, "R6 fall independent of skew", f, 14);
   endtask

   task automatic t_no_pulse();
      int r, f, v;
      setup(1, 5, 5, 9, 8'h08);
      measure(40, r, f);
      check(r == -1, "R7 no pulse", r, -1);
      rd(3'd5, v);
      check(v == 1, "R7 R8 flag1 only", v, 1);
      check(irq_evt1 == 1'b1, "R8 irq", int'(irq_evt1), 1);
      setup(1, 6, 4, 9, 8'h00);
      measure(40, r, f);
      check(r == -1, "R7 skew above width", r, -1);
   endtask

   task automatic t_mask_and_unreached();
      int r, f, v;
      setup(2, 1, 4, 5, 8'h00);
      measure(30, r, f);
      rd(3'd5, v);
      check(v == 1, "R9 event beyond phase unreached", v, 1);
      check(!irq_evt1, "R8 masked", int'(irq_evt1), 0);
   endtask

   task automatic t_restart();
      int r, f;
      setup(10, 0, 2, 20, 8'h00);
      @(negedge clk); ref_pin = 1'b1;
      repeat (2) @(negedge clk);
      ref_pin = 1'b0;
      repeat (6) @(negedge clk);
      measure(40, r, f);
      check(r == 14, "R4 restart rise", r, 14);
      check(f == 16, "R4 restart fall", f, 16);
   endtask

   task automatic t_prescale();
      int r, f;
      setup(1, 1, 3, 9, 8'h01);
      measure(100, r, f);
      check(r > 0 && f - r == 8, "R2 prescaled width", f - r, 8);
   endtask

   task automatic t_gate();
      int r, f, v;
      setup(1, 0, 2, 9, 8'h04);
      gate_pin = 1'b0;
      @(negedge clk); ref_pin = 1'b1;
      repeat (2) @(negedge clk);
      ref_pin = 1'b0;
      repeat (20) @(negedge clk);
      rd(3'd6, v);
      check(v == 0, "R3 gated phase", v, 0);
      check(!pwm_out, "R3 gated out", int'(pwm_out), 0);
      gate_pin = 1'b1;
      r = -1;
      for (int i = 1; i <= 20; i++) begin
         @(posedge clk); #1;
         if (pwm_out && r < 0) r = i;
      end
      check(r == 4, "R3 gate open rise", r, 4);
      gate_pin = 1'b0;
   endtask

   task automatic t_external();
      int r, f;
      setup(2, 1, 4, 9, 8'h06);
      gate_pin = 1'b0;
      @(negedge clk); ref_pin = 1'b1;
      repeat (2) @(negedge clk);
      ref_pin = 1'b0;
      repeat (6) @(negedge clk);
      r = -1; f = -1;
      for (int k = 1; k <= 10; k++) begin
         ext_clk_pin = 1'b1;
         repeat (4) @(negedge clk);
         ext_clk_pin = 1'b0;
         repeat (4) @(negedge clk);
         if (pwm_out && r < 0) r = k;
         if (!pwm_out && r >= 0 && f < 0) f = k;
      end
      check(r == 4, "R2 R3 ext rise edge", r, 4);
      check(f == 7, "R2 ext fall edge", f, 7);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl_readback();
      t_basic();
      t_skew_zero();
      t_trail_indep();
      t_no_pulse();
      t_mask_and_unreached();
      t_restart();
      t_prescale();
      t_gate();
      t_external();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule